// File: doc/BRIEF.md
# Glitch-Free Clock Stop Gate

This block gates one group of generated clocks, such as a bus-clock group or a processor-clock group. An active-low stop request arrives asynchronously. It is passed through a synchronizer into the group's own clock domain. A small controller then either parks every output of the group at logic low or releases them again. Each gated output has an enable that changes only while the source clock is low. As a result, every high pulse an output drives is a complete high phase of the source clock, and no pulse is ever cut short.

After a release, the group must keep running for a set number of clock pulses before a new stop can take effect. The parameter `MIN_RUN` sets this count. Typical values are 10 for a slow bus group and 100 for a processor group. A stop that arrives inside this window waits until the window ends. A companion free-running output shares the source clock and ignores the stop request completely.

A per-output enable mask, normally driven from configuration registers, holds chosen outputs low all the time. A separate enable does the same for the free-running output.

Top module: `clk_stop_gate`

## Requirements
- R1: When the run window has expired and `stop_n` falls during the low phase before source rising edge k, the gated outputs still give high pulses at edges k, k+1 and k+2. From edge k+3 they give none (default `SYNC_STAGES` = 2).
- R2: While the group is stopped, every gated output stays at logic low.
- R3: When `stop_n` rises during the low phase before edge r, the gated outputs stay low at edges r, r+1 and r+2, and the first high pulse comes at edge r+3. A stop request lasting one cycle therefore gives exactly one missing pulse.
- R4: After a restart, the group gives at least `MIN_RUN` high pulses before a pending stop takes effect. A stop asserted earlier is held back until that count is reached.
- R5: `clk_free` follows the source clock whenever `free_en` is 1, whatever the state of `stop_n`.
- R6: An output whose bit in `out_en` is 0 (bit i controls `clk_gated[i]`), or `clk_free` when `free_en` is 0, is held low. A change of mask takes effect at the next falling edge of the source clock. So a change made during a low phase first shows at the second rising edge after it.
- R7: Every high pulse on any output lasts exactly half a source period. Every low interval lasts half a period plus a whole number of periods.
- R8: While `rst_n` is low, all outputs are low. After reset the group runs with the run window already expired.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src | input | 1 | Source clock of the group |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_n | input | 1 | Asynchronous active-low stop request |
| out_en | input | NUM_OUT | Per-output enable mask, 1 = output may run |
| free_en | input | 1 | Enable of the free-running output |
| clk_gated | output | NUM_OUT | Gated clock outputs |
| clk_free | output | 1 | Free-running output, not affected by stop |

## Verification
The hardest case to reach is a stop request that arrives inside the minimum-run window. Seen from the ports, this looks the same as a stop that is simply late. The stimulus releases the group and lowers `stop_n` again on the very next cycle. The bench then counts the pulses that follow and confirms that exactly `MIN_RUN` pulses appear before the group parks. A one-cycle stop glitch and mask changes made while the group is parked cover the remaining edge-alignment cases. A pulse-width monitor checks every high and low interval for runts.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;
   typedef enum logic {
      GATE_PARK = 1'b0,
      GATE_RUN  = 1'b1
   } gate_state_e;
endpackage

// File: rtl/clkstop_sync.sv
module clkstop_sync #(
   parameter int STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_n,
   input  logic async_n_i,
   output logic stop_req_o
);
   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk_i or negedge rst_n) begin
      if (!rst_n) chain_q <= '1;
      else        chain_q <= {chain_q[STAGES-2:0], async_n_i};
   end

   assign stop_req_o = ~chain_q[STAGES-1];
endmodule

// File: rtl/clkstop_ctrl.sv
module clkstop_ctrl
   import clkstop_pkg::*;
#(
   parameter int MIN_RUN = 10
) (
   input  logic clk_i,
   input  logic rst_n,
   input  logic stop_req_i,
   output logic run_o
);
   localparam int CW = $clog2(MIN_RUN + 1);
   localparam logic [CW-1:0] RELOAD = CW'(MIN_RUN - 1);

   gate_state_e state_q;
   logic [CW-1:0] win_q;

   always_ff @(posedge clk_i or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= GATE_RUN;
         win_q   <= '0;
      end else begin
         case (state_q)
            GATE_RUN: begin
               if (win_q != '0)     win_q   <= win_q - 1'b1;
               else if (stop_req_i) state_q <= GATE_PARK;
            end
            default: begin
               if (!stop_req_i) begin
                  state_q <= GATE_RUN;
                  win_q   <= RELOAD;
               end
            end
         endcase
      end
   end

   assign run_o = (state_q == GATE_RUN);

   // R4
   window_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
      (state_q == GATE_RUN && win_q != '0) |=> (state_q == GATE_RUN));

   // R1
   stop_taken_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
      (state_q == GATE_RUN && win_q == '0 && stop_req_i) |=> (state_q == GATE_PARK));

   // R3
   resume_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
      (state_q == GATE_PARK && !stop_req_i) |=> (state_q == GATE_RUN && win_q == RELOAD));
endmodule

// File: rtl/clkstop_gate.sv
module clkstop_gate #(
   parameter int WIDTH = 1
) (
   input  logic             clk_i,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic [WIDTH-1:0] mask_i,
   output logic [WIDTH-1:0] clk_o
);
   for (genvar i = 0; i < WIDTH; i++) begin : g_lane
      logic en_q;

      always_ff @(negedge clk_i or negedge rst_n) begin
         if (!rst_n) en_q <= 1'b0;
         else        en_q <= run_i & mask_i[i];
      end

      assign clk_o[i] = clk_i & en_q;

      // R2
      park_low_chk: assert property (@(negedge clk_i) disable iff (!rst_n)
         !run_i |=> !en_q);

      // R6
      mask_low_chk: assert property (@(negedge clk_i) disable iff (!rst_n)
         !mask_i[i] |=> !en_q);
   end
endmodule

// File: rtl/clk_stop_gate.sv
module clk_stop_gate #(
   parameter int NUM_OUT     = 6,
   parameter int SYNC_STAGES = 2,
   parameter int MIN_RUN     = 10
) (
   input  logic               clk_src,
   input  logic               rst_n,
   input  logic               stop_n,
   input  logic [NUM_OUT-1:0] out_en,
   input  logic               free_en,
   output logic [NUM_OUT-1:0] clk_gated,
   output logic               clk_free
);
   if (NUM_OUT < 1) begin : g_bad_width
      $error("NUM_OUT must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (MIN_RUN < 1) begin : g_bad_run
      $error("MIN_RUN must be at least 1");
   end

   logic stop_req;
   logic run;

   clkstop_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk_i      (clk_src),
      .rst_n      (rst_n),
      .async_n_i  (stop_n),
      .stop_req_o (stop_req)
   );

   clkstop_ctrl #(.MIN_RUN(MIN_RUN)) i_ctrl (
      .clk_i      (clk_src),
      .rst_n      (rst_n),
      .stop_req_i (stop_req),
      .run_o      (run)
   );

   clkstop_gate #(.WIDTH(NUM_OUT)) i_gate (
      .clk_i  (clk_src),
      .rst_n  (rst_n),
      .run_i  (run),
      .mask_i (out_en),
      .clk_o  (clk_gated)
   );

   clkstop_gate #(.WIDTH(1)) i_free (
      .clk_i  (clk_src),
      .rst_n  (rst_n),
      .run_i  (1'b1),
      .mask_i (free_en),
      .clk_o  (clk_free)
   );
endmodule

// File: tb/test_clk_stop_gate.sv
`timescale 1ns/1ps
module test_clk_stop_gate;
   localparam int  N      = 6;
   localparam int  MINRUN = 10;
   localparam real HALF   = 2.5;
   localparam real PER    = 5.0;

   logic         clk_src = 1'b0;
   logic         rst_n   = 1'b0;
   logic         stop_n  = 1'b1;
   logic [N-1:0] out_en  = '1;
   logic         free_en = 1'b1;
   logic [N-1:0] clk_gated;
   logic         clk_free;

   always #2.5 clk_src = ~clk_src;

   clk_stop_gate #(.NUM_OUT(N), .SYNC_STAGES(2), .MIN_RUN(MINRUN)) i_clk_stop_gate (
      .clk_src   (clk_src),
      .rst_n     (rst_n),
      .stop_n    (stop_n),
      .out_en    (out_en),
      .free_en   (free_en),
      .clk_gated (clk_gated),
      .clk_free  (clk_free)
   );

   typedef struct {
      logic [N-1:0] g;
      logic         f;
      string        tag;
   } exp_t;

   exp_t sb_q[$];
   int checks = 0;
   int fails  = 0;

   localparam logic [N-1:0] ALL = '1;
   localparam logic [N-1:0] SUB = 6'b101010;

   // driver: called at a falling edge; sets inputs, queues the expectation for the next rising edge
   task automatic cyc(input logic s, input logic [N-1:0] m, input logic fe,
                      input logic [N-1:0] eg, input logic ef, input string tag);
      exp_t e;
      #1;
      stop_n  = s;
      out_en  = m;
      free_en = fe;
      e.g = eg; e.f = ef; e.tag = tag;
      sb_q.push_back(e);
      @(negedge clk_src);
   endtask

   // monitor: samples in the middle of each high phase
   initial begin
      forever begin
         @(posedge clk_src);
         #1;
         if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            checks++;
            if (clk_gated !== e.g || clk_free !== e.f) begin
               fails++;
               $display("FAIL %s: gated=%b free=%b expected gated=%b free=%b",
                        e.tag, clk_gated, clk_free, e.g, e.f);
            end
         end
      end
   end

   // R7: pulse-width monitor on each output
   wire [N:0] mon_sig = {clk_free, clk_gated};
   for (genvar k = 0; k <= N; k++) begin : g_mon
      realtime t_rise = -1.0;
      realtime t_fall = -1.0;
      always @(posedge mon_sig[k]) begin
         if (t_fall >= 0.0) begin
            realtime w;
            int      n;
            w = $realtime - t_fall;
            n = $rtoi((w - HALF) / PER + 0.5);
            checks++;
            if (w < HALF - 0.01 || (w - (HALF + n * PER)) > 0.01 || (w - (HALF + n * PER)) < -0.01) begin
               fails++;
               $display("FAIL R7 runt low on output %0d: width=%0f expected half period plus whole periods", k, w);
            end
         end
         t_rise = $realtime;
      end
      always @(negedge mon_sig[k]) begin
         if (t_rise >= 0.0) begin
            realtime w;
            w = $realtime - t_rise;
            checks++;
            if (w > HALF + 0.01 || w < HALF - 0.01) begin
               fails++;
               $display("FAIL R7 runt high on output %0d: width=%0f expected %0f", k, w, HALF);
            end
         end
         t_fall = $realtime;
      end
   end

   initial begin
      #100000;
      fails++;
      $display("FAIL R8 watchdog expired: pending=%0d expected 0", sb_q.size());
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      @(negedge clk_src);
      // R8 reset state
      repeat (3) cyc(1'b1, ALL, 1'b1, '0, 1'b0, "R8 reset low");
      #1 rst_n = 1'b1;
      @(negedge clk_src);
      repeat (4) cyc(1'b1, ALL, 1'b1, ALL, 1'b1, "R8 run after reset");
      // R1 stop latency with expired window
      repeat (3) cyc(1'b0, ALL, 1'b1, ALL, 1'b1, "R1 pulses before stop");
      repeat (6) cyc(1'b0, ALL, 1'b1, '0, 1'b1, "R2 R5 parked low, free runs");
      // R3 restart latency and full first pulse
      repeat (3) cyc(1'b1, ALL, 1'b1, '0, 1'b1, "R3 still parked");
      cyc(1'b1, ALL, 1'b1, ALL, 1'b1, "R3 first pulse");
      // R4 stop inside the run window waits for MINRUN pulses
      repeat (MINRUN - 1) cyc(1'b0, ALL, 1'b1, ALL, 1'b1, "R4 held by run window");
      repeat (4) cyc(1'b0, ALL, 1'b1, '0, 1'b1, "R4 stop after window");
      // restart and let window expire
      repeat (3) cyc(1'b1, ALL, 1'b1, '0, 1'b1, "R3 parked before restart");
      repeat (13) cyc(1'b1, ALL, 1'b1, ALL, 1'b1, "R3 running");
      // R3 one-cycle stop glitch: a single missing pulse
      cyc(1'b0, ALL, 1'b1, ALL, 1'b1, "R3 short stop edge k");
      repeat (2) cyc(1'b1, ALL, 1'b1, ALL, 1'b1, "R3 short stop pipeline");
      cyc(1'b1, ALL, 1'b1, '0, 1'b1, "R3 short stop gap");
      cyc(1'b1, ALL, 1'b1, ALL, 1'b1, "R3 short stop resume");
      // R6 mask change
      cyc(1'b1, SUB, 1'b1, ALL, 1'b1, "R6 old mask still");
      repeat (4) cyc(1'b1, SUB, 1'b1, SUB, 1'b1, "R6 new mask");
      cyc(1'b1, SUB, 1'b0, SUB, 1'b1, "R6 free old enable");
      repeat (3) cyc(1'b1, SUB, 1'b0, SUB, 1'b0, "R6 free masked");
      // R1 stop with partial mask, free re-enabled
      cyc(1'b0, SUB, 1'b1, SUB, 1'b0, "R1 stop edge k");
      repeat (2) cyc(1'b0, SUB, 1'b1, SUB, 1'b1, "R1 stop edges k+1 k+2");
      repeat (5) cyc(1'b0, SUB, 1'b1, '0, 1'b1, "R5 free runs while stopped");
      repeat (3) cyc(1'b0, ALL, 1'b1, '0, 1'b1, "R6 mask change while parked");
      repeat (3) cyc(1'b1, ALL, 1'b1, '0, 1'b1, "R3 release wait");
      repeat (3) cyc(1'b1, ALL, 1'b1, ALL, 1'b1, "R3 running full mask");
      repeat (3) @(negedge clk_src);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule